// File: doc/BRIEF.md
# Complementary Output Dead-Time Generator

This block turns one reference waveform into a pair of complementary drive signals, for example for the high and low switches of a half bridge. Each output has its own enable and polarity bit. A shared 8-bit dead-time value makes each output wait that many clock cycles after its own activating edge of the reference. The main output waits after the reference rises. The complementary output waits after the reference falls. Falling edges are never delayed, so the two outputs can never be active at once.

A master output enable forces both pins to their inactive levels. While it is low the dead-time counter is held cleared. When it returns, the first activation of either output waits a full dead time, exactly as after a reference edge. A reference pulse no longer than the dead time is swallowed completely. With only one output enabled, that output follows the reference without any delay.

Top module: `dead_time_gen`

## Requirements
- R1: During and right after reset, both internal active levels are 0. Each pin therefore shows its polarity bit.
- R2: Each pin equals its internal active level XOR its polarity bit. Polarity 0 means active-high and polarity 1 means active-low.
- R3: With both enables and the master enable set, a reference rise sampled at clock edge k makes the main output active from edge k+dt onward, for as long as the reference stays high.
- R4: With both enables and the master enable set, a reference fall sampled at edge k makes the complementary output active from edge k+dt onward, for as long as the reference stays low.
- R5: A dead-time value of 0 adds no delay. Each output then becomes active right after the edge that samples its activating reference level.
- R6: A reference level lasting W cycles produces W-dt active cycles on the matching output when W>dt, and no pulse when W<=dt.
- R7: Each output goes inactive right after the edge that samples the reference leaving its activating level. Both outputs are never active in the same cycle.
- R8: With only the main enable set, the main output follows the sampled reference with no dead time. With only the complementary enable set, the complementary output follows the inverted sampled reference with no dead time.
- R9: An output whose enable is 0 stays at its inactive level, whatever the reference does.
- R10: While the master enable is sampled low, both outputs are inactive and the counter is cleared. After the master enable is sampled high again at edge k, the first activation comes at edge k+dt.
- R11: The cycle counter saturates at 255 and never wraps. With dt=255, an output stays active for as long as its reference level is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference waveform |
| dt_i | input | 8 | Dead time in clock cycles |
| main_en_i | input | 1 | Main output enable |
| comp_en_i | input | 1 | Complementary output enable |
| main_pol_i | input | 1 | Main output polarity (1 = active-low) |
| comp_pol_i | input | 1 | Complementary output polarity (1 = active-low) |
| out_en_i | input | 1 | Master output enable |
| main_o | output | 1 | Main drive output |
| comp_o | output | 1 | Complementary drive output |

## Verification
Directed pulses with widths below, equal to and above the dead time tell a correctly delayed edge apart from one delayed by a cycle too many or too few, and tell suppression apart from a one-cycle glitch. Separate edges measure the rise delay after the reference rises and after it falls, so a swapped or missing delay on either side shows up. Runs with a single enable, with the master enable dropped and restored, and with dt=255 held long check the undelayed path, the counter restart on re-enable and saturation. Random toggling of the reference, the enables, the polarities and the master enable is compared against a cycle model every cycle.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int unsigned DT_W   = 8;
  localparam int unsigned N_CHAN = 2;
  localparam int unsigned CH_MAIN = 0;
  localparam int unsigned CH_COMP = 1;
endpackage

// File: rtl/dtg_edge_timer.sv
module dtg_edge_timer #(
  parameter int unsigned DT_W = dtg_pkg::DT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_i,
  input  logic            oe_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            ref_q_o,
  output logic            oe_q_o,
  output logic            dt_done_o
);
  localparam logic [DT_W-1:0] CNT_MAX = '1;

  logic            ref_q, oe_q;
  logic [DT_W-1:0] cnt_q;
  logic            restart;

  // enable rise counts as an edge so dead time applies after re-enable
  assign restart = !oe_i || !oe_q || (ref_i != ref_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      oe_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      ref_q <= ref_i;
      oe_q  <= oe_i;
      if (restart)               cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ref_q_o   = ref_q;
  assign oe_q_o    = oe_q;
  assign dt_done_o = (cnt_q >= dt_i);

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !restart) |=> (cnt_q == CNT_MAX)); // R11
  AST_OE_CLEARS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/dtg_channel.sv
module dtg_channel (
  input  logic lvl_i,
  input  logic oe_q_i,
  input  logic own_en_i,
  input  logic other_en_i,
  input  logic dt_done_i,
  output logic act_o
);
  logic gap_ok;

  // dead time only when the partner output is also in use
  assign gap_ok = !other_en_i || dt_done_i;
  assign act_o  = oe_q_i && own_en_i && lvl_i && gap_ok;
endmodule

// File: rtl/dtg_out_stage.sv
module dtg_out_stage (
  input  logic act_i,
  input  logic pol_i,
  output logic pin_o
);
  assign pin_o = act_i ^ pol_i;
endmodule

// File: rtl/dead_time_gen.sv
module dead_time_gen #(
  parameter int unsigned DT_W = dtg_pkg::DT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dt_i,
  input  logic            main_en_i,
  input  logic            comp_en_i,
  input  logic            main_pol_i,
  input  logic            comp_pol_i,
  input  logic            out_en_i,
  output logic            main_o,
  output logic            comp_o
);
  import dtg_pkg::*;

  logic              ref_q, oe_q, dt_done;
  logic [N_CHAN-1:0] en_w, pol_w, lvl_w, act_w, pin_w;

  assign en_w[CH_MAIN]  = main_en_i;
  assign en_w[CH_COMP]  = comp_en_i;
  assign pol_w[CH_MAIN] = main_pol_i;
  assign pol_w[CH_COMP] = comp_pol_i;
  assign lvl_w[CH_MAIN] = ref_q;
  assign lvl_w[CH_COMP] = !ref_q;

  dtg_edge_timer #(.DT_W(DT_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_i     (ref_i),
    .oe_i      (out_en_i),
    .dt_i      (dt_i),
    .ref_q_o   (ref_q),
    .oe_q_o    (oe_q),
    .dt_done_o (dt_done)
  );

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    dtg_channel i_chan (
      .lvl_i      (lvl_w[g]),
      .oe_q_i     (oe_q),
      .own_en_i   (en_w[g]),
      .other_en_i (en_w[N_CHAN-1-g]),
      .dt_done_i  (dt_done),
      .act_o      (act_w[g])
    );
    dtg_out_stage i_out (
      .act_i (act_w[g]),
      .pol_i (pol_w[g]),
      .pin_o (pin_w[g])
    );
  end

  assign main_o = pin_w[CH_MAIN];
  assign comp_o = pin_w[CH_COMP];

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_w[CH_MAIN] && act_w[CH_COMP])); // R7
  AST_IDLE_ON_OE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |=> (act_w == '0)); // R10
  AST_MAIN_RISE_NEEDS_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_w[CH_MAIN]) |-> ref_q); // R3
  AST_ZERO_DT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dt_i == '0 && oe_q && main_en_i) |-> (act_w[CH_MAIN] == ref_q)); // R5
endmodule

// File: tb/test_dead_time_gen.sv
module test_dead_time_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_s = 1'b0;
  logic [7:0] dt = 8'd0;
  logic       men = 1'b0, cen = 1'b0, mpol = 1'b0, cpol = 1'b0, oe = 1'b0;
  logic       main_o, comp_o;

  int n_chk = 0;
  int n_err = 0;
  bit model_on = 1'b0;

  // bench cycle model
  bit m_ref = 1'b0, m_oe = 1'b0;
  int m_cnt = 0;

  always #4ns clk = ~clk;

  dead_time_gen i_dead_time_gen (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .dt_i(dt),
    .main_en_i(men), .comp_en_i(cen), .main_pol_i(mpol), .comp_pol_i(cpol),
    .out_en_i(oe), .main_o(main_o), .comp_o(comp_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ref = 1'b0; m_oe = 1'b0; m_cnt = 0;
    end else begin
      if (!oe || !m_oe || ref_s != m_ref) m_cnt = 0;
      else if (m_cnt < 255) m_cnt = m_cnt + 1;
      m_ref = ref_s;
      m_oe  = oe;
    end
  end

  function automatic bit exp_main();
    return (m_oe && men && m_ref && (!cen || m_cnt >= int'(dt))) ^ mpol;
  endfunction

  function automatic bit exp_comp();
    return (m_oe && cen && !m_ref && (!men || m_cnt >= int'(dt))) ^ cpol;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (model_on) begin
      chk("R2 R3 R4 R7 R8 R9 R10 main model", main_o, exp_main());
      chk("R2 R3 R4 R7 R8 R9 R10 comp model", comp_o, exp_comp());
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // cycles until the selected output becomes active; -1 if never
  task automatic first_active(input bit sel_comp, input int limit, output int idx);
    idx = -1;
    for (int i = 0; i < limit; i++) begin
      step();
      if (((sel_comp ? comp_o : main_o) ^ (sel_comp ? cpol : mpol)) && idx < 0) idx = i;
    end
  endtask

  // high pulse of w cycles, returns number of active main cycles
  task automatic pulse_count(input int w, output int cnt);
    cnt = 0;
    ref_s = 1'b0; settle(int'(dt) + 3);
    ref_s = 1'b1;
    for (int i = 0; i < w; i++) begin
      step();
      if (main_o ^ mpol) cnt++;
    end
    ref_s = 1'b0;
    for (int i = 0; i < int'(dt) + 3; i++) begin
      step();
      if (main_o ^ mpol) cnt++;
    end
  endtask

  initial begin
    #(200000 * 8ns);
    n_err++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int idx, cnt;
    void'($urandom(32'd20240611));
    // R1 reset state
    mpol = 1'b0; cpol = 1'b1; ref_s = 1'b1; men = 1'b1; cen = 1'b1; oe = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 main in reset", main_o, 0);
    chk("R1 comp in reset", comp_o, 1);
    rst_n = 1'b1;
    cpol = 1'b0; ref_s = 1'b0; oe = 1'b0;
    step();
    chk("R1 main after reset", main_o, 0);
    chk("R1 comp after reset", comp_o, 0);
    model_on = 1'b1;
    oe = 1'b1;
    settle(4);

    // R3 main rise delay
    dt = 8'd3; ref_s = 1'b0; settle(6);
    ref_s = 1'b1; first_active(1'b0, 10, idx);
    chk("R3 main rise delay", idx, 3);
    // R4 comp rise delay
    ref_s = 1'b0; first_active(1'b1, 10, idx);
    chk("R4 comp rise delay", idx, 3);
    // R5 zero dead time
    dt = 8'd0; ref_s = 1'b1; first_active(1'b0, 4, idx);
    chk("R5 main no delay", idx, 0);
    ref_s = 1'b0; first_active(1'b1, 4, idx);
    chk("R5 comp no delay", idx, 0);
    // R6 pulse widths around the dead time
    dt = 8'd4;
    pulse_count(6, cnt); chk("R6 wide pulse", cnt, 2);
    pulse_count(5, cnt); chk("R6 pulse dt+1", cnt, 1);
    pulse_count(4, cnt); chk("R6 pulse equal dt", cnt, 0);
    pulse_count(2, cnt); chk("R6 narrow pulse", cnt, 0);
    // R2 active-low polarity
    mpol = 1'b1;
    pulse_count(7, cnt); chk("R2 active-low pulse", cnt, 3);
    mpol = 1'b0;
    // R7 immediate fall
    dt = 8'd2; ref_s = 1'b1; settle(5);
    ref_s = 1'b0; step();
    chk("R7 main falls at once", main_o, 0);
    chk("R7 comp waits", comp_o, 0);
    // R8 single enables
    cen = 1'b0; dt = 8'd5; ref_s = 1'b0; settle(3);
    ref_s = 1'b1; first_active(1'b0, 8, idx);
    chk("R8 main alone no delay", idx, 0);
    chk("R9 comp disabled", comp_o, 0);
    men = 1'b0; cen = 1'b1; settle(2);
    ref_s = 1'b0; first_active(1'b1, 8, idx);
    chk("R8 comp alone no delay", idx, 0);
    // R9 both disabled
    cen = 1'b0;
    pulse_count(9, cnt); chk("R9 main disabled pulse", cnt, 0);
    // R10 master enable
    men = 1'b1; cen = 1'b1; dt = 8'd4; ref_s = 1'b1; settle(8);
    oe = 1'b0; step();
    chk("R10 main idle", main_o, 0);
    chk("R10 comp idle", comp_o, 0);
    settle(3);
    oe = 1'b1; first_active(1'b0, 10, idx);
    chk("R10 dead time after re-enable", idx, 4);
    // R11 saturation
    dt = 8'd255; ref_s = 1'b0; settle(3);
    ref_s = 1'b1; first_active(1'b0, 300, idx);
    chk("R11 dt 255 delay", idx, 255);
    chk("R11 still active after saturation", main_o, 1);

    // random mix
    dt = 8'd2;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) ref_s = ~ref_s;
      if ($urandom_range(40) == 0) dt = 8'($urandom_range(7));
      if ($urandom_range(60) == 0) men = ~men;
      if ($urandom_range(60) == 0) cen = ~cen;
      if ($urandom_range(80) == 0) mpol = ~mpol;
      if ($urandom_range(80) == 0) cpol = ~cpol;
      if ($urandom_range(50) == 0) oe = ~oe;
      step();
      chk("R7 no overlap", int'((main_o ^ mpol) && (comp_o ^ cpol)), 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule